// File: doc/BRIEF.md
# Single-Stage Insertion Sorter

This block restores descending weight order over a small set of per-pixel mixture components after exactly one of them has been updated. The N-1 components that were not touched arrive in the order they held before, highest weight at the top. The one updated component sits in the bottom slot and may now belong anywhere. Because only that one entry can be out of place, the block does not need a general sorting network. It compares the updated weight against every other weight at the same time, and each output slot then picks its entry through a single multiplexer level. The number of logic levels stays the same for any N.

Each entry carries a weight and an opaque data word, such as packed mean and variance fields. The data word travels with its weight. The result is registered once, and a valid strobe follows it one cycle behind the input strobe. When the input strobe is low, the output registers hold their values. The entry count N defaults to 3, and the bench also builds the block with N = 5.

Top module: `wsort_insert`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and every bit of weight_o and data_o is 0.
- R2: valid_o equals valid_i as it was at the previous rising clock edge (latency one cycle).
- R3: Whenever valid_o is 1, the output weights do not increase from slot 0 (top) to slot N-1 (bottom).
- R4: The output is the input with the bottom-slot entry (index N-1) moved. It lands directly below every other entry whose weight is greater than or equal to its own, and directly above every entry with a strictly smaller weight.
- R5: On equal weights, the updated entry goes below the existing entries with that weight. The existing entries keep the higher positions.
- R6: The entries at indices 0 to N-2 appear in the output in the same relative order they had at the input.
- R7: Each data word leaves in the same slot as the weight it entered with.
- R8: A cycle with valid_i low leaves weight_o and data_o unchanged, whatever weight_i and data_i carry.
- R9: Slot k uses bits [k*WEIGHT_W +: WEIGHT_W] of the weight buses and bits [k*DATA_W +: DATA_W] of the data buses. Slot 0 is the top, and slot N-1 is the bottom and updated slot on input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input set is valid this cycle |
| weight_i | input | N*WEIGHT_W | Weights; slots 0..N-2 ordered, slot N-1 updated |
| data_i | input | N*DATA_W | Data word per slot |
| valid_o | output | 1 | Output set is valid |
| weight_o | output | N*WEIGHT_W | Weights in descending order |
| data_o | output | N*DATA_W | Data words following their weights |

## Verification
The bench builds two copies of the block, one with N = 3 and one with N = 5, both with 4-bit weights. With N = 3 it sweeps every ordered pair of weights against every updated weight. This covers every insertion point and every tie position. With N = 5 it sweeps all ordered sets drawn from a four-value range, which makes ties dense, and then adds pseudo-random ordered sets over the full range. Unique data tags on every entry expose any slot swap or any reordering of the untouched entries.

// File: rtl/wsort_pkg.sv
package wsort_pkg;

  typedef enum logic [1:0] {
    SEL_KEEP  = 2'd0,
    SEL_UPD   = 2'd1,
    SEL_SHIFT = 2'd2
  } slot_sel_e;

  // beaten: the updated weight is strictly greater than this slot's entry
  function automatic slot_sel_e pick_src(input logic beaten_here,
                                         input logic beaten_above,
                                         input logic is_top);
    if (!beaten_here)                return SEL_KEEP;
    else if (is_top || !beaten_above) return SEL_UPD;
    else                              return SEL_SHIFT;
  endfunction

endpackage

// File: rtl/wsort_cmp_bank.sv
module wsort_cmp_bank #(
  parameter int N        = 3,
  parameter int WEIGHT_W = 16
) (
  input  logic [N*WEIGHT_W-1:0] weight_i,
  output logic [N-1:0]          beaten_o
);
  localparam int UPD = N - 1;

  logic [WEIGHT_W-1:0] upd_w;
  assign upd_w = weight_i[UPD*WEIGHT_W +: WEIGHT_W];

  for (genvar i = 0; i < N - 1; i++) begin : g_cmp
    // strict compare keeps the existing entry above on a tie
    assign beaten_o[i] = upd_w > weight_i[i*WEIGHT_W +: WEIGHT_W];
  end
  assign beaten_o[UPD] = 1'b1;

endmodule

// File: rtl/wsort_slot_mux.sv
module wsort_slot_mux
  import wsort_pkg::*;
#(
  parameter int WEIGHT_W = 16,
  parameter int DATA_W   = 28,
  parameter bit IS_TOP   = 1'b0
) (
  input  logic                beaten_here_i,
  input  logic                beaten_above_i,
  input  logic [WEIGHT_W-1:0] keep_w_i,
  input  logic [DATA_W-1:0]   keep_d_i,
  input  logic [WEIGHT_W-1:0] upd_w_i,
  input  logic [DATA_W-1:0]   upd_d_i,
  input  logic [WEIGHT_W-1:0] shift_w_i,
  input  logic [DATA_W-1:0]   shift_d_i,
  output logic [WEIGHT_W-1:0] w_o,
  output logic [DATA_W-1:0]   d_o
);
  slot_sel_e sel;

  always_comb begin
    sel = pick_src(beaten_here_i, beaten_above_i, IS_TOP);
    unique case (sel)
      SEL_KEEP: begin w_o = keep_w_i;  d_o = keep_d_i;  end
      SEL_UPD:  begin w_o = upd_w_i;   d_o = upd_d_i;   end
      default:  begin w_o = shift_w_i; d_o = shift_d_i; end
    endcase
  end

endmodule

// File: rtl/wsort_out_reg.sv
module wsort_out_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/wsort_insert.sv
module wsort_insert #(
  parameter int N        = 3,
  parameter int WEIGHT_W = 16,
  parameter int DATA_W   = 28
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [N*WEIGHT_W-1:0] weight_i,
  input  logic [N*DATA_W-1:0]   data_i,
  output logic                  valid_o,
  output logic [N*WEIGHT_W-1:0] weight_o,
  output logic [N*DATA_W-1:0]   data_o
);
  localparam int UPD   = N - 1;
  localparam int ENT_W = WEIGHT_W + DATA_W;

  logic [N-1:0]          beaten;
  logic [N*WEIGHT_W-1:0] w_nxt;
  logic [N*DATA_W-1:0]   d_nxt;

  wsort_cmp_bank #(.N(N), .WEIGHT_W(WEIGHT_W)) u_cmp (
    .weight_i (weight_i),
    .beaten_o (beaten)
  );

  for (genvar j = 0; j < N; j++) begin : g_slot
    localparam int ABOVE = (j == 0) ? 0 : j - 1;
    wsort_slot_mux #(
      .WEIGHT_W (WEIGHT_W),
      .DATA_W   (DATA_W),
      .IS_TOP   (j == 0)
    ) u_mux (
      .beaten_here_i  (beaten[j]),
      .beaten_above_i (beaten[ABOVE]),
      .keep_w_i       (weight_i[j*WEIGHT_W +: WEIGHT_W]),
      .keep_d_i       (data_i[j*DATA_W +: DATA_W]),
      .upd_w_i        (weight_i[UPD*WEIGHT_W +: WEIGHT_W]),
      .upd_d_i        (data_i[UPD*DATA_W +: DATA_W]),
      .shift_w_i      (weight_i[ABOVE*WEIGHT_W +: WEIGHT_W]),
      .shift_d_i      (data_i[ABOVE*DATA_W +: DATA_W]),
      .w_o            (w_nxt[j*WEIGHT_W +: WEIGHT_W]),
      .d_o            (d_nxt[j*DATA_W +: DATA_W])
    );
  end

  logic [N*ENT_W-1:0] q;

  wsort_out_reg #(.W(N*ENT_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .d_i     ({w_nxt, d_nxt}),
    .valid_o (valid_o),
    .q_o     (q)
  );

  assign weight_o = q[N*ENT_W-1 -: N*WEIGHT_W];
  assign data_o   = q[N*DATA_W-1:0];

endmodule

// File: rtl/wsort_insert_chk.sv
module wsort_insert_chk #(
  parameter int N        = 3,
  parameter int WEIGHT_W = 16,
  parameter int DATA_W   = 28
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic [N*WEIGHT_W-1:0] weight_i,
  input logic [N*DATA_W-1:0]   data_i,
  input logic                  valid_o,
  input logic [N*WEIGHT_W-1:0] weight_o,
  input logic [N*DATA_W-1:0]   data_o
);
  localparam int SUM_W = WEIGHT_W + $clog2(N) + 1;

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  logic             ordered;
  logic [SUM_W-1:0] sum_in, sum_out;
  always_comb begin
    ordered = 1'b1;
    sum_in  = '0;
    sum_out = '0;
    for (int k = 0; k < N; k++) begin
      sum_in  = sum_in  + SUM_W'(weight_i[k*WEIGHT_W +: WEIGHT_W]);
      sum_out = sum_out + SUM_W'(weight_o[k*WEIGHT_W +: WEIGHT_W]);
      if (k > 0 && weight_o[k*WEIGHT_W +: WEIGHT_W] > weight_o[(k-1)*WEIGHT_W +: WEIGHT_W])
        ordered = 1'b0;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && weight_o == '0 && data_o == '0));

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> valid_o == $past(valid_i));

  assert_descending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ordered);

  assert_weight_sum_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(valid_i)) |-> sum_out == $past(sum_in));

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(valid_i)) |-> ($stable(weight_o) && $stable(data_o)));

endmodule

bind wsort_insert wsort_insert_chk #(
  .N(N), .WEIGHT_W(WEIGHT_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .weight_i(weight_i),
  .data_i(data_i), .valid_o(valid_o), .weight_o(weight_o), .data_o(data_o)
);

// File: tb/tb_wsort_insert.sv
module tb_wsort_insert;
  localparam int WW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            v3 = 1'b0, v5 = 1'b0;
  logic [3*WW-1:0] w3_i = '0;
  logic [3*DW-1:0] d3_i = '0;
  logic [5*WW-1:0] w5_i = '0;
  logic [5*DW-1:0] d5_i = '0;
  logic            v3_o, v5_o;
  logic [3*WW-1:0] w3_o;
  logic [3*DW-1:0] d3_o;
  logic [5*WW-1:0] w5_o;
  logic [5*DW-1:0] d5_o;

  wsort_insert #(.N(3), .WEIGHT_W(WW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v3), .weight_i(w3_i), .data_i(d3_i),
    .valid_o(v3_o), .weight_o(w3_o), .data_o(d3_o)
  );

  wsort_insert #(.N(5), .WEIGHT_W(WW), .DATA_W(DW)) dut5 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v5), .weight_i(w5_i), .data_i(d5_i),
    .valid_o(v5_o), .weight_o(w5_o), .data_o(d5_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int cw[5], cd[5], ew[5], ed[5];
  int seed = 32'h1234_5678;

  // reference: updated entry goes below every entry with weight >= its own
  task automatic build_exp(input int n);
    int p = 0;
    for (int i = 0; i < n - 1; i++) if (cw[i] >= cw[n-1]) p++;
    for (int j = 0; j < n; j++) begin
      if (j < p)       begin ew[j] = cw[j];   ed[j] = cd[j];   end
      else if (j == p) begin ew[j] = cw[n-1]; ed[j] = cd[n-1]; end
      else             begin ew[j] = cw[j-1]; ed[j] = cd[j-1]; end
    end
  endtask

  task automatic apply(input int n, input int tag);
    bit tie = 0;
    for (int k = 0; k < n; k++) cd[k] = ((k << 4) | (tag & 15)) & 8'hFF;
    for (int k = 0; k < n - 1; k++) if (cw[k] == cw[n-1]) tie = 1;
    build_exp(n);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (n == 3) begin w3_i[k*WW +: WW] = WW'(cw[k]); d3_i[k*DW +: DW] = DW'(cd[k]); end
      else        begin w5_i[k*WW +: WW] = WW'(cw[k]); d5_i[k*DW +: DW] = DW'(cd[k]); end
    end
    if (n == 3) v3 = 1'b1; else v5 = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (n == 3) v3 = 1'b0; else v5 = 1'b0;
    checks++;
    // covers R3 R4 R5 R6 R7 R9 on each vector
    for (int j = 0; j < n; j++) begin
      int gw, gd;
      gw = (n == 3) ? int'(w3_o[j*WW +: WW]) : int'(w5_o[j*WW +: WW]);
      gd = (n == 3) ? int'(d3_o[j*DW +: DW]) : int'(d5_o[j*DW +: DW]);
      if (gw != ew[j] || gd != ed[j] || ((n == 3) ? v3_o : v5_o) !== 1'b1) begin
        fails++;
        $display("FAIL %s N=%0d slot %0d: got w=%0d d=%0h expected w=%0d d=%0h",
                 tie ? "R5" : "R4_R6_R7", n, j, gw, gd, ew[j], ed[j]);
        break;
      end
    end
  endtask

  function automatic int rnd16();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 15;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #3;
    checks++;  // R1
    if (v3_o !== 1'b0 || w3_o !== '0 || d5_o !== '0 || v5_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state: got v=%b w=%h expected v=0 w=0", v3_o, w3_o);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R2: idle input gives idle output
    if (v3_o !== 1'b0) begin
      fails++; $display("FAIL R2 idle: got %b expected 0", v3_o);
    end

    // N=3: every ordered pair against every updated weight
    for (int a = 0; a < 16; a++)
      for (int b = 0; b <= a; b++)
        for (int u = 0; u < 16; u++) begin
          cw[0] = a; cw[1] = b; cw[2] = u;
          apply(3, a + b + u);
        end

    // R2: strobe drops one cycle after the last valid input
    @(negedge clk);
    checks++;
    if (v3_o !== 1'b0) begin
      fails++; $display("FAIL R2 strobe drop: got %b expected 0", v3_o);
    end

    // R8: change inputs with valid low, outputs must hold
    cw[0] = 9; cw[1] = 5; cw[2] = 7;
    apply(3, 3);
    @(negedge clk);
    w3_i = '1; d3_i = '1;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (w3_o !== {4'd5, 4'd7, 4'd9} || d3_o[DW-1:0] !== 8'h03) begin
      fails++; $display("FAIL R8 hold: got w=%h expected 579", w3_o);
    end

    // N=5: dense ties over weights 0..3
    for (int a = 0; a < 4; a++)
      for (int b = 0; b <= a; b++)
        for (int c = 0; c <= b; c++)
          for (int e = 0; e <= c; e++)
            for (int u = 0; u < 4; u++) begin
              cw[0] = a; cw[1] = b; cw[2] = c; cw[3] = e; cw[4] = u;
              apply(5, a + u);
            end

    // N=5: pseudo-random ordered sets over full range
    for (int t = 0; t < 400; t++) begin
      for (int k = 0; k < 4; k++) cw[k] = rnd16();
      for (int x = 0; x < 4; x++)
        for (int y = 0; y < 3 - x; y++)
          if (cw[y] < cw[y+1]) begin int s = cw[y]; cw[y] = cw[y+1]; cw[y+1] = s; end
      cw[4] = rnd16();
      apply(5, t);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule